// File: doc/BRIEF.md
# Line Read Prefetch Buffer

This block holds one cache line of read data on its way from a 64-bit memory and cache side to a 32-bit bus master. The line is four Qword slots. Two fill paths load it: memory read data enters slot by slot in sequence, and cache write-back data is written straight into a slot chosen by the caller. The caller uses the direct path to handle write-backs that arrive in a non-linear burst order. It drops the leading Qwords the master did not ask for and places each kept Qword so that slot 0 holds the requested Qword and the slots above it follow in linear order.

The 32-bit side drains one Dword for each strobe, starting at either half of slot 0. Each slot has a valid bit. When the slot under the drain pointer is not yet filled, the ready output is low and a strobe is held off. With every Dword the block presents a Dword parity bit, taken from the byte parity stored with the slot. A configuration input sampled during reset chooses whether the byte parity of write-back data is taken from its source or generated from the data, for caches that keep no parity. A start pulse opens a new transaction. It clears every valid bit, resets both pointers and picks the even or odd first Dword.

Top module: `line_prefetch_buf`

## Requirements
- R1: While reset is asserted and after it is released, `ready_o` is 0 until a slot is filled by a new transaction.
- R2: After `start_i`, memory writes (`mem_we_i`) fill slots 0, 1, 2, 3 in that order, one Qword per cycle. A memory write that arrives after four have been stored is ignored.
- R3: The drain is linear. Each accepted strobe (`drain_i` while `ready_o` is 1) advances by one Dword. Within a slot, bits 31:0 come out before bits 63:32. With `odd_i`=0 at start the first Dword is bits 31:0 of slot 0; with `odd_i`=1 it is bits 63:32 of slot 0.
- R4: `ready_o` is 0 when the slot under the drain pointer is not valid, and a strobe in that state does not move the drain pointer.
- R5: `start_i` clears all valid bits and resets both pointers. Fill requests on either path in the same cycle as `start_i` are ignored.
- R6: A write-back store (`wb_we_i`) writes the Qword into slot `wb_slot_i` (0 to 3) and marks that slot valid, whatever the memory fill pointer holds.
- R7: When `wb_we_i` and `mem_we_i` arrive in the same cycle, the write-back is stored and the memory write is dropped without advancing the memory fill pointer.
- R8: `dpar_o` is the XOR of the four stored byte parity bits of the Dword shown (parity bits 3:0 belong to bits 31:0 and bits 7:4 to bits 63:32). Each byte parity bit is even parity of its byte, so correct parity makes `dpar_o` equal to the XOR of the 32 data bits.
- R9: `cfg_gen_par_i` is sampled while reset is asserted. When it is 1, write-back byte parity is generated from the data and `wb_par_i` is ignored. Memory byte parity is always stored as given.
- R10: Once the last Dword of the line (slot 3, bits 63:32) has been drained, `ready_o` stays 0 until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gen_par_i | input | 1 | Generate write-back parity (sampled during reset) |
| start_i | input | 1 | Begin a new transaction |
| odd_i | input | 1 | With start: first Dword is the upper half of slot 0 |
| mem_we_i | input | 1 | Sequential memory fill strobe |
| mem_data_i | input | 64 | Memory Qword |
| mem_par_i | input | 8 | Memory byte parity |
| wb_we_i | input | 1 | Direct write-back store strobe |
| wb_slot_i | input | 2 | Target slot of the write-back store |
| wb_data_i | input | 64 | Write-back Qword |
| wb_par_i | input | 8 | Write-back byte parity |
| drain_i | input | 1 | Drain strobe from the 32-bit side |
| dw_o | output | 32 | Dword under the drain pointer |
| dpar_o | output | 1 | Parity of that Dword |
| ready_o | output | 1 | Dword under the pointer is valid |

## Verification
The hardest case to reach is a write-back burst in order 1-0-3-2, where the requested Qword lands in slot 0, Qword 0 is discarded and slot 3 is never filled. The drain must still come out linear and must stop with a stall rather than run into the empty slot. The stimulus reproduces this by issuing stores to slots 0, 2 and 1 in burst order, skipping the discarded Qword. The scoreboard expects six Dwords and then `ready_o` low. A second awkward case is a write-back and a memory fill in the same cycle. It is shown by a later memory fill landing in slot 0 rather than slot 1.

// File: rtl/lpb_pkg.sv
package lpb_pkg;
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_MEM  = 2'd1,
      SRC_WB   = 2'd2
   } fill_src_e;
endpackage

// File: rtl/lpb_par_gen.sv
module lpb_par_gen #(
   parameter int QW_W        = 64,
   parameter bit GEN_SUPPORT = 1'b1
) (
   input  logic [QW_W-1:0]   data_i,
   input  logic [QW_W/8-1:0] par_i,
   input  logic              gen_en_i,
   output logic [QW_W/8-1:0] par_o
);
   localparam int NB = QW_W / 8;

   generate
      if (GEN_SUPPORT) begin : g_gen
         logic [NB-1:0] calc;
         for (genvar b = 0; b < NB; b++) begin : g_byte
            assign calc[b] = ^data_i[b*8 +: 8];
         end
         assign par_o = gen_en_i ? calc : par_i;
      end else begin : g_pass
         logic unused_en;
         assign unused_en = gen_en_i;
         assign par_o     = par_i;
      end
   endgenerate
endmodule

// File: rtl/lpb_slots.sv
module lpb_slots #(
   parameter int QW_W  = 64,
   parameter int SLOTS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_i,
   input  logic                     we_i,
   input  logic [$clog2(SLOTS)-1:0] slot_i,
   input  logic [QW_W-1:0]          data_i,
   input  logic [QW_W/8-1:0]        par_i,
   output logic [QW_W-1:0]          data_o [SLOTS],
   output logic [QW_W/8-1:0]        par_o  [SLOTS],
   output logic [SLOTS-1:0]         valid_o
);
   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         logic hit;
         assign hit = we_i && !clr_i && (slot_i == s[$clog2(SLOTS)-1:0]);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_o[s] <= 1'b0;
               data_o[s]  <= '0;
               par_o[s]   <= '0;
            end else if (clr_i) begin
               valid_o[s] <= 1'b0;
            end else if (hit) begin
               valid_o[s] <= 1'b1;
               data_o[s]  <= data_i;
               par_o[s]   <= par_i;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lpb_drain.sv
module lpb_drain #(
   parameter int QW_W  = 64,
   parameter int SLOTS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic                          odd_i,
   input  logic                          drain_i,
   input  logic [QW_W-1:0]               data_i [SLOTS],
   input  logic [QW_W/8-1:0]             par_i  [SLOTS],
   input  logic [SLOTS-1:0]              valid_i,
   output logic [QW_W/2-1:0]             dw_o,
   output logic                          dpar_o,
   output logic                          ready_o,
   output logic [$clog2(2*SLOTS):0]      ptr_o
);
   localparam int DW_W = QW_W / 2;
   localparam int NB   = QW_W / 8;
   localparam int PW   = $clog2(2*SLOTS) + 1;

   logic [PW-1:0]            ptr;
   logic [PW-3:0]            slot;
   logic                     half;
   logic [NB/2-1:0]          bpar;

   assign slot    = ptr[PW-2:1];
   assign half    = ptr[0];
   assign ready_o = !ptr[PW-1] && valid_i[slot];
   assign dw_o    = half ? data_i[slot][QW_W-1:DW_W] : data_i[slot][DW_W-1:0];
   assign bpar    = half ? par_i[slot][NB-1:NB/2]    : par_i[slot][NB/2-1:0];
   assign dpar_o  = ^bpar;
   assign ptr_o   = ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= {1'b1, {(PW-1){1'b0}}};
      end else if (start_i) begin
         ptr <= {{(PW-1){1'b0}}, odd_i};
      end else if (drain_i && ready_o) begin
         ptr <= ptr + 1'b1;
      end
   end
endmodule

// File: rtl/line_prefetch_buf.sv
module line_prefetch_buf #(
   parameter int QW_W        = 64,
   parameter int SLOTS       = 4,
   parameter bit GEN_SUPPORT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_gen_par_i,
   input  logic                     start_i,
   input  logic                     odd_i,
   input  logic                     mem_we_i,
   input  logic [QW_W-1:0]          mem_data_i,
   input  logic [QW_W/8-1:0]        mem_par_i,
   input  logic                     wb_we_i,
   input  logic [$clog2(SLOTS)-1:0] wb_slot_i,
   input  logic [QW_W-1:0]          wb_data_i,
   input  logic [QW_W/8-1:0]        wb_par_i,
   input  logic                     drain_i,
   output logic [QW_W/2-1:0]        dw_o,
   output logic                     dpar_o,
   output logic                     ready_o
);
   import lpb_pkg::*;

   localparam int SW = $clog2(SLOTS);
   localparam int NB = QW_W / 8;
   localparam int PW = $clog2(2*SLOTS) + 1;

   generate
      if (QW_W % 16 != 0 || QW_W < 16) begin : g_bad_width
         $error("QW_W must be a multiple of 16");
      end
      if (SLOTS < 2 || (1 << SW) != SLOTS) begin : g_bad_slots
         $error("SLOTS must be a power of two, at least 2");
      end
   endgenerate

   logic            gen_q;
   logic [SW:0]     wr_ptr;
   fill_src_e       src;
   logic [SW-1:0]   w_slot;
   logic [QW_W-1:0] w_data;
   logic [NB-1:0]   w_par;
   logic [NB-1:0]   wb_par_eff;
   logic [QW_W-1:0] slot_data [SLOTS];
   logic [NB-1:0]   slot_par  [SLOTS];
   logic [SLOTS-1:0] slot_valid;
   logic [PW-1:0]   rd_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) gen_q <= cfg_gen_par_i;
   end

   always_comb begin
      src = SRC_NONE;
      if (!start_i) begin
         if (wb_we_i)                   src = SRC_WB;
         else if (mem_we_i && !wr_ptr[SW]) src = SRC_MEM;
      end
   end

   lpb_par_gen #(.QW_W(QW_W), .GEN_SUPPORT(GEN_SUPPORT)) u_par_gen (
      .data_i   (wb_data_i),
      .par_i    (wb_par_i),
      .gen_en_i (gen_q),
      .par_o    (wb_par_eff)
   );

   assign w_slot = (src == SRC_WB) ? wb_slot_i  : wr_ptr[SW-1:0];
   assign w_data = (src == SRC_WB) ? wb_data_i  : mem_data_i;
   assign w_par  = (src == SRC_WB) ? wb_par_eff : mem_par_i;

   always_ff @(posedge clk) begin
      if (!rst_n)              wr_ptr <= '0;
      else if (start_i)        wr_ptr <= '0;
      else if (src == SRC_MEM) wr_ptr <= wr_ptr + 1'b1;
   end

   lpb_slots #(.QW_W(QW_W), .SLOTS(SLOTS)) u_slots (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (start_i),
      .we_i    (src != SRC_NONE),
      .slot_i  (w_slot),
      .data_i  (w_data),
      .par_i   (w_par),
      .data_o  (slot_data),
      .par_o   (slot_par),
      .valid_o (slot_valid)
   );

   lpb_drain #(.QW_W(QW_W), .SLOTS(SLOTS)) u_drain (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .odd_i   (odd_i),
      .drain_i (drain_i),
      .data_i  (slot_data),
      .par_i   (slot_par),
      .valid_i (slot_valid),
      .dw_o    (dw_o),
      .dpar_o  (dpar_o),
      .ready_o (ready_o),
      .ptr_o   (rd_ptr)
   );
endmodule

// File: rtl/lpb_checker.sv
module lpb_checker #(
   parameter int SLOTS = 4,
   parameter int PW    = 4,
   parameter int SW    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             drain_i,
   input logic             mem_we_i,
   input logic             wb_we_i,
   input logic             ready_o,
   input logic [PW-1:0]    rd_ptr,
   input logic [SW:0]      wr_ptr,
   input logic [SLOTS-1:0] slot_valid
);
   assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (slot_valid == '0) && !ready_o);

   assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_i && !ready_o && !start_i) |=> $stable(rd_ptr));

   assert_drain_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_i && ready_o && !start_i) |=> rd_ptr == $past(rd_ptr) + 1'b1);

   assert_line_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ptr[PW-1] |-> !ready_o);

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ptr <= SLOTS);

   assert_wb_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_we_i && mem_we_i && !start_i) |=> $stable(wr_ptr));
endmodule

bind line_prefetch_buf lpb_checker #(
   .SLOTS (SLOTS),
   .PW    ($clog2(2*SLOTS) + 1),
   .SW    ($clog2(SLOTS))
) u_lpb_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .drain_i    (drain_i),
   .mem_we_i   (mem_we_i),
   .wb_we_i    (wb_we_i),
   .ready_o    (ready_o),
   .rd_ptr     (rd_ptr),
   .wr_ptr     (wr_ptr),
   .slot_valid (slot_valid)
);

// File: tb/line_prefetch_buf_bench.sv
module line_prefetch_buf_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n, cfg_gen_par_i, start_i, odd_i;
   logic        mem_we_i, wb_we_i, drain_i;
   logic [63:0] mem_data_i, wb_data_i;
   logic [7:0]  mem_par_i, wb_par_i;
   logic [1:0]  wb_slot_i;
   logic [31:0] dw_o;
   logic        dpar_o, ready_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [32:0] exp_q [$];
   string       tag_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   line_prefetch_buf u_line_prefetch_buf (
      .clk(clk), .rst_n(rst_n), .cfg_gen_par_i(cfg_gen_par_i),
      .start_i(start_i), .odd_i(odd_i),
      .mem_we_i(mem_we_i), .mem_data_i(mem_data_i), .mem_par_i(mem_par_i),
      .wb_we_i(wb_we_i), .wb_slot_i(wb_slot_i), .wb_data_i(wb_data_i),
      .wb_par_i(wb_par_i), .drain_i(drain_i),
      .dw_o(dw_o), .dpar_o(dpar_o), .ready_o(ready_o)
   );

   function automatic logic [7:0] bpar(input logic [63:0] d);
      logic [7:0] p;
      for (int b = 0; b < 8; b++) p[b] = ^d[b*8 +: 8];
      return p;
   endfunction

   task automatic check1(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: %s got %h expected %h", tag, what, got, exp);
      end
   endtask

   // driver side: push expected Dwords of a Qword (lower half first)
   task automatic push_qw(input string tag, input logic [63:0] d,
                          input logic [7:0] p, input bit skip_lo);
      if (!skip_lo) begin
         exp_q.push_back({^p[3:0], d[31:0]});
         tag_q.push_back(tag);
      end
      exp_q.push_back({^p[7:4], d[63:32]});
      tag_q.push_back(tag);
   endtask

   // monitor: drain and compare against the scoreboard until it is empty
   task automatic drain_all();
      while (exp_q.size() > 0) begin
         logic [32:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check1(t, "ready_o", {31'd0, ready_o}, 32'd1);
         check1(t, "dw_o", dw_o, e[31:0]);
         check1("R8", "dpar_o", {31'd0, dpar_o}, {31'd0, e[32]});
         drain_i = 1'b1;
         @(negedge clk);
      end
      drain_i = 1'b0;
   endtask

   task automatic do_reset(input bit gen);
      rst_n = 1'b0; cfg_gen_par_i = gen;
      start_i = 0; odd_i = 0; mem_we_i = 0; wb_we_i = 0; drain_i = 0;
      mem_data_i = '0; wb_data_i = '0; mem_par_i = '0; wb_par_i = '0; wb_slot_i = '0;
      repeat (3) @(negedge clk);
      check1("R1", "ready_o in reset", {31'd0, ready_o}, 32'd0);
      rst_n = 1'b1; cfg_gen_par_i = 1'b0;
      @(negedge clk);
      check1("R1", "ready_o after reset", {31'd0, ready_o}, 32'd0);
   endtask

   task automatic do_start(input bit odd);
      start_i = 1'b1; odd_i = odd;
      @(negedge clk);
      start_i = 1'b0; odd_i = 1'b0;
   endtask

   task automatic mem_put(input logic [63:0] d, input logic [7:0] p);
      mem_we_i = 1'b1; mem_data_i = d; mem_par_i = p;
      @(negedge clk);
      mem_we_i = 1'b0;
   endtask

   task automatic wb_put(input logic [1:0] s, input logic [63:0] d, input logic [7:0] p);
      wb_we_i = 1'b1; wb_slot_i = s; wb_data_i = d; wb_par_i = p;
      @(negedge clk);
      wb_we_i = 1'b0;
   endtask

   task automatic expect_stall(input string tag);
      check1(tag, "ready_o low", {31'd0, ready_o}, 32'd0);
      drain_i = 1'b1;
      @(negedge clk);
      drain_i = 1'b0;
      check1(tag, "ready_o still low", {31'd0, ready_o}, 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] q [4];
      for (int i = 0; i < 4; i++) q[i] = {32'hA000_0000 + 32'(i*2+1), 32'h5000_0000 + 32'(i*2)} ^ 64'h0123_4567_89AB_CDEF;

      @(negedge clk);
      do_reset(1'b0);

      // R2, R3: sequential memory fill, even start, propagated parity (one bad byte)
      do_start(1'b0);
      for (int i = 0; i < 4; i++) begin
         logic [7:0] p;
         p = bpar(q[i]) ^ ((i == 2) ? 8'h10 : 8'h00);
         mem_put(q[i], p);
         push_qw((i == 0) ? "R3" : "R2", q[i], p, 1'b0);
      end
      drain_all();
      expect_stall("R10");

      // R3: odd start, fill overflow R2 (fifth memory write ignored)
      do_start(1'b1);
      for (int i = 0; i < 4; i++) begin
         mem_put(~q[i], bpar(~q[i]));
         push_qw("R3", ~q[i], bpar(~q[i]), i == 0);
      end
      mem_put(64'hDEAD_BEEF_DEAD_BEEF, 8'h00);
      drain_all();
      expect_stall("R2");

      // R4: stall before fill, resume after fill, stall on next empty slot
      do_start(1'b0);
      expect_stall("R4");
      mem_put(q[3], bpar(q[3]));
      push_qw("R4", q[3], bpar(q[3]), 1'b0);
      drain_all();
      expect_stall("R4");
      mem_put(q[1], bpar(q[1]));
      push_qw("R4", q[1], bpar(q[1]), 1'b0);
      drain_all();

      // R5: fill requests in the start cycle are ignored
      start_i = 1'b1; mem_we_i = 1'b1; mem_data_i = q[0]; mem_par_i = bpar(q[0]);
      wb_we_i = 1'b1; wb_slot_i = 2'd0; wb_data_i = q[1]; wb_par_i = bpar(q[1]);
      @(negedge clk);
      start_i = 1'b0; mem_we_i = 1'b0; wb_we_i = 1'b0;
      expect_stall("R5");
      mem_put(q[2], bpar(q[2]));
      push_qw("R5", q[2], bpar(q[2]), 1'b0);
      drain_all();

      // R6: write-back burst order 1-0-3-2, requested Qword 1, wrong source parity kept (R8)
      do_start(1'b0);
      wb_put(2'd0, q[1], bpar(q[1]) ^ 8'h01);
      push_qw("R6", q[1], bpar(q[1]) ^ 8'h01, 1'b0);
      @(negedge clk);                       // Qword 0 of the burst is dropped
      wb_put(2'd2, q[3], bpar(q[3]));
      wb_put(2'd1, q[2], bpar(q[2]));
      push_qw("R6", q[2], bpar(q[2]), 1'b0);
      push_qw("R6", q[3], bpar(q[3]), 1'b0);
      drain_all();
      expect_stall("R6");

      // R7: write-back and memory fill together
      do_start(1'b0);
      mem_we_i = 1'b1; mem_data_i = 64'h1111_2222_3333_4444; mem_par_i = 8'h00;
      wb_we_i = 1'b1; wb_slot_i = 2'd1; wb_data_i = q[0]; wb_par_i = bpar(q[0]);
      @(negedge clk);
      mem_we_i = 1'b0; wb_we_i = 1'b0;
      mem_put(q[3], bpar(q[3]));
      push_qw("R7", q[3], bpar(q[3]), 1'b0);
      push_qw("R7", q[0], bpar(q[0]), 1'b0);
      drain_all();

      // R9: generate mode, write-back parity ignored, memory parity kept
      do_reset(1'b1);
      do_start(1'b0);
      mem_put(q[0], bpar(q[0]) ^ 8'h80);
      wb_put(2'd1, q[2], ~bpar(q[2]));
      push_qw("R9", q[0], bpar(q[0]) ^ 8'h80, 1'b0);
      push_qw("R9", q[2], bpar(q[2]), 1'b0);
      drain_all();
      expect_stall("R10");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule